// File: doc/BRIEF.md
# Page Map Entry Cache with Refill

This block keeps a handful of recently used page map entries close to the address translation path, so that most translations do not need a main-memory read. Each lookup names a 7-bit virtual page and the mode of the access (User or Exec). The cache is fully associative, and its tag holds both the page number and the mode. A hit returns the stored 16-bit map word one cycle after the lookup is accepted. A miss computes the memory word address of the entry and issues one read on a request/acknowledge port. When the read returns, the word is written into the least recently used slot and returned to the requester.

Two base registers hold the physical page numbers of the User map and the Exec map. Each map is 128 words long and sits at the start of a 256-word physical page. An optional shared-upper-Exec mode is switched on when the Exec base is written. In this mode, Exec pages at or above a threshold take their map words from the unused second half of the User map page. Loading a new User map therefore also moves those Exec entries. Protection checking is not part of this block.

Top module: `pmc_top`

## Requirements
- R1: After reset no entry is valid, `lk_ready` is 1, and `mem_req` and `rsp_valid` are 0.
- R2: The tag is the virtual page together with the mode bit (`lk_exec`: 1 for Exec, 0 for User). The same page number in the other mode misses and is stored as a separate entry.
- R3: A lookup that hits gives `rsp_valid`=1, `rsp_hit`=1 and the stored word in the cycle after it is accepted, with no memory request.
- R4: A miss raises `mem_req` in the cycle after acceptance and holds `mem_addr` steady until `mem_ack`. The address is {User base, 0, page} for User lookups and {Exec base, 0, page} for Exec lookups. In the cycle after `mem_ack`, `rsp_valid`=1, `rsp_hit`=0 and `rsp_entry` equals `mem_rdata`, and the word stays cached.
- R5: When the shared-upper-Exec mode is on, an Exec lookup of a page at or above EPP_LO (default 96) reads from address {User base, 1, page}.
- R6: When the cache is full, a fill replaces the entry that was least recently hit or filled.
- R7: `lk_ready` is 0 from the acceptance of a miss until its response. Only one refill is outstanding at a time.
- R8: A write to the User base (`cfg_wr`=1, `cfg_sel`=0) invalidates every User entry and every Exec entry at or above EPP_LO. Lower Exec entries are kept.
- R9: A write to the Exec base (`cfg_sel`=1) loads the mode bit from `cfg_epp` and invalidates every Exec entry. User entries are kept.
- R10: A pulse on `inv_all` invalidates every entry.
- R11: If an invalidation covers the page and mode of a refill that is in progress, the refill is still answered but its word is not kept. The next lookup of that page misses.
- R12: The entry count is a parameter. Only capacity changes with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | 7 | Virtual page number |
| lk_exec | input | 1 | 1 = Exec mode, 0 = User mode |
| lk_ready | output | 1 | Lookup accepted when high with lk_valid |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_hit | output | 1 | Response came from the cache |
| rsp_entry | output | 16 | Page map word |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 17 | Memory word address |
| mem_ack | input | 1 | Read data valid, ends request |
| mem_rdata | input | 16 | Read data |
| cfg_wr | input | 1 | Base register write strobe |
| cfg_sel | input | 1 | 0 = User base, 1 = Exec base |
| cfg_base | input | 9 | Physical page number of the map |
| cfg_epp | input | 1 | Shared-upper-Exec mode, taken on Exec base writes |
| inv_all | input | 1 | Invalidate all entries |

## Verification
The bench builds the block with its defaults: 8 entries, 7-bit pages, 9-bit base page numbers and the shared-Exec threshold at page 96. With 8 entries, a run of eight distinct fills followed by re-touches is short enough to expose the exact eviction order. Using pages 5 and 100 places one page below the threshold and one above it. That lets the bench check both address forms and the selective invalidation rules against the same cached contents. The memory answers after a fixed delay, so a base write can be placed inside a refill window.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  typedef enum logic {ST_IDLE, ST_FETCH} pmc_state_e;

  // True when an invalidation event covers an entry of the given mode/page.
  function automatic logic pmc_kill(input logic is_exec, input int unsigned vpn,
                                    input int unsigned epp_lo, input logic inv_user,
                                    input logic inv_exec, input logic inv_all);
    logic upper;
    upper = is_exec && (vpn >= epp_lo);
    return inv_all || (inv_user && (!is_exec || upper)) || (inv_exec && is_exec);
  endfunction

endpackage

// File: rtl/pmc_addr.sv
module pmc_addr #(
  parameter int VPN_W  = 7,
  parameter int PPN_W  = 9,
  parameter int EPP_LO = 96,
  localparam int ADDR_W = PPN_W + 1 + VPN_W
) (
  input  logic [VPN_W-1:0]  vpn,
  input  logic              is_exec,
  input  logic              epp_on,
  input  logic [PPN_W-1:0]  user_base,
  input  logic [PPN_W-1:0]  exec_base,
  output logic [ADDR_W-1:0] word_addr
);
  logic upper;

  always_comb begin
    upper = is_exec && epp_on && (int'(vpn) >= EPP_LO);
    if (is_exec && !upper) word_addr = {exec_base, 1'b0, vpn};
    else                   word_addr = {user_base, upper, vpn};
  end
endmodule

// File: rtl/pmc_age.sv
module pmc_age #(
  parameter int N = 8,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_idx,
  output logic [IDX_W-1:0] victim_idx
);
  logic [IDX_W-1:0] age_q [N];
  logic [IDX_W-1:0] age_d [N];
  logic [N-1:0]     oldest;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      age_d[i] = age_q[i];
      if (touch_en) begin
        if (IDX_W'(i) == touch_idx)            age_d[i] = '0;
        else if (age_q[i] < age_q[touch_idx])  age_d[i] = age_q[i] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) age_q[i] <= IDX_W'(i);
    end else if (touch_en) begin
      for (int i = 0; i < N; i++) age_q[i] <= age_d[i];
    end
  end

  always_comb begin
    victim_idx = '0;
    for (int i = 0; i < N; i++) begin
      oldest[i] = (age_q[i] == IDX_W'(N - 1));
      if (oldest[i]) victim_idx = IDX_W'(i);
    end
  end

  AST_ONE_VICTIM: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(oldest) == 1); // R6
endmodule

// File: rtl/pmc_store.sv
module pmc_store
  import pmc_pkg::*;
#(
  parameter int N      = 8,
  parameter int VPN_W  = 7,
  parameter int DATA_W = 16,
  parameter int EPP_LO = 96,
  localparam int IDX_W = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VPN_W-1:0]  q_vpn,
  input  logic              q_exec,
  output logic              hit,
  output logic [IDX_W-1:0]  hit_idx,
  output logic [DATA_W-1:0] hit_data,
  input  logic              fill_en,
  input  logic [IDX_W-1:0]  fill_idx,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic              fill_exec,
  input  logic [DATA_W-1:0] fill_data,
  input  logic              inv_user,
  input  logic              inv_exec,
  input  logic              inv_all
);
  logic [N-1:0]      vld_q, vld_d, hit_vec;
  logic [VPN_W-1:0]  vpn_q [N];
  logic              ex_q  [N];
  logic [DATA_W-1:0] dat_q [N];
  logic              fill_kill;

  assign fill_kill = pmc_kill(fill_exec, int'(fill_vpn), EPP_LO, inv_user, inv_exec, inv_all);

  for (genvar g = 0; g < N; g++) begin : g_slot
    logic kill_g, wr_g;
    assign hit_vec[g] = vld_q[g] && (vpn_q[g] == q_vpn) && (ex_q[g] == q_exec);
    assign kill_g     = pmc_kill(ex_q[g], int'(vpn_q[g]), EPP_LO, inv_user, inv_exec, inv_all);
    assign wr_g       = fill_en && (fill_idx == IDX_W'(g));
    assign vld_d[g]   = wr_g ? !fill_kill : (vld_q[g] && !kill_g);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (fill_en && (fill_idx == IDX_W'(i))) begin
        vpn_q[i] <= fill_vpn;
        ex_q[i]  <= fill_exec;
        dat_q[i] <= fill_data;
      end
    end
  end

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < N; i++) if (hit_vec[i]) hit_idx = IDX_W'(i);
  end
  assign hit      = |hit_vec;
  assign hit_data = dat_q[hit_idx];

  AST_ONE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec)); // R2
  AST_INV_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> (vld_q == '0)); // R10
endmodule

// File: rtl/pmc_top.sv
module pmc_top
  import pmc_pkg::*;
#(
  parameter int N_ENTRIES = 8,
  parameter int VPN_W     = 7,
  parameter int PPN_W     = 9,
  parameter int DATA_W    = 16,
  parameter int EPP_LO    = 96,
  localparam int ADDR_W   = PPN_W + 1 + VPN_W,
  localparam int IDX_W    = $clog2(N_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic              lk_exec,
  output logic              lk_ready,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [DATA_W-1:0] rsp_entry,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              cfg_wr,
  input  logic              cfg_sel,
  input  logic [PPN_W-1:0]  cfg_base,
  input  logic              cfg_epp,
  input  logic              inv_all
);
  pmc_state_e        state_q, state_d;
  logic [PPN_W-1:0]  ubase_q, ebase_q;
  logic              epp_q;
  logic [VPN_W-1:0]  pend_vpn_q, pend_vpn_d;
  logic              pend_ex_q, pend_ex_d;
  logic              drop_q, drop_d;
  logic              req_q, req_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              rv_q, rv_d, rh_q, rh_d;
  logic [DATA_W-1:0] re_q, re_d;

  logic              accept, lk_hit, fill_en, touch_en, inv_user, inv_exec, pend_kill;
  logic [IDX_W-1:0]  hit_idx, victim_idx, touch_idx;
  logic [DATA_W-1:0] hit_data;
  logic [ADDR_W-1:0] calc_addr;

  assign lk_ready  = (state_q == ST_IDLE);
  assign accept    = lk_valid && lk_ready;
  assign inv_user  = cfg_wr && !cfg_sel;
  assign inv_exec  = cfg_wr && cfg_sel;
  assign pend_kill = pmc_kill(pend_ex_q, int'(pend_vpn_q), EPP_LO, inv_user, inv_exec, inv_all);
  assign fill_en   = (state_q == ST_FETCH) && mem_ack && !drop_q;
  assign touch_en  = (accept && lk_hit) || fill_en;
  assign touch_idx = fill_en ? victim_idx : hit_idx;

  pmc_addr #(.VPN_W(VPN_W), .PPN_W(PPN_W), .EPP_LO(EPP_LO)) addr_i (
    .vpn(lk_vpn), .is_exec(lk_exec), .epp_on(epp_q),
    .user_base(ubase_q), .exec_base(ebase_q), .word_addr(calc_addr));

  pmc_store #(.N(N_ENTRIES), .VPN_W(VPN_W), .DATA_W(DATA_W), .EPP_LO(EPP_LO)) store_i (
    .clk(clk), .rst_n(rst_n), .q_vpn(lk_vpn), .q_exec(lk_exec),
    .hit(lk_hit), .hit_idx(hit_idx), .hit_data(hit_data),
    .fill_en(fill_en), .fill_idx(victim_idx), .fill_vpn(pend_vpn_q),
    .fill_exec(pend_ex_q), .fill_data(mem_rdata),
    .inv_user(inv_user), .inv_exec(inv_exec), .inv_all(inv_all));

  pmc_age #(.N(N_ENTRIES)) age_i (
    .clk(clk), .rst_n(rst_n), .touch_en(touch_en), .touch_idx(touch_idx),
    .victim_idx(victim_idx));

  always_comb begin
    state_d    = state_q;
    pend_vpn_d = pend_vpn_q;
    pend_ex_d  = pend_ex_q;
    drop_d     = drop_q;
    req_d      = req_q;
    addr_d     = addr_q;
    rv_d       = 1'b0;
    rh_d       = rh_q;
    re_d       = re_q;
    if (state_q == ST_IDLE) begin
      if (accept && lk_hit) begin
        rv_d = 1'b1;
        rh_d = 1'b1;
        re_d = hit_data;
      end else if (accept) begin
        state_d    = ST_FETCH;
        req_d      = 1'b1;
        addr_d     = calc_addr;
        pend_vpn_d = lk_vpn;
        pend_ex_d  = lk_exec;
        drop_d     = 1'b0;
      end
    end else begin
      drop_d = drop_q || pend_kill;
      if (mem_ack) begin
        state_d = ST_IDLE;
        req_d   = 1'b0;
        rv_d    = 1'b1;
        rh_d    = 1'b0;
        re_d    = mem_rdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      ubase_q    <= '0;
      ebase_q    <= '0;
      epp_q      <= 1'b0;
      pend_vpn_q <= '0;
      pend_ex_q  <= 1'b0;
      drop_q     <= 1'b0;
      req_q      <= 1'b0;
      addr_q     <= '0;
      rv_q       <= 1'b0;
      rh_q       <= 1'b0;
      re_q       <= '0;
    end else begin
      state_q    <= state_d;
      pend_vpn_q <= pend_vpn_d;
      pend_ex_q  <= pend_ex_d;
      drop_q     <= drop_d;
      req_q      <= req_d;
      addr_q     <= addr_d;
      rv_q       <= rv_d;
      rh_q       <= rh_d;
      re_q       <= re_d;
      if (inv_user) ubase_q <= cfg_base;
      if (inv_exec) begin
        ebase_q <= cfg_base;
        epp_q   <= cfg_epp;
      end
    end
  end

  assign mem_req   = req_q;
  assign mem_addr  = addr_q;
  assign rsp_valid = rv_q;
  assign rsp_hit   = rh_q;
  assign rsp_entry = re_q;

  AST_HIT_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready && lk_hit) |=> (rsp_valid && rsp_hit && !mem_req)); // R3
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr))); // R4
  AST_FILL_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack) |=> (rsp_valid && !rsp_hit && rsp_entry == $past(mem_rdata))); // R4
  AST_MISS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready && !lk_hit) |=> (mem_req && !lk_ready)); // R7
endmodule

// File: tb/pmc_top_tb.sv
module pmc_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        lk_valid, lk_exec, lk_ready, rsp_valid, rsp_hit;
  logic [6:0]  lk_vpn;
  logic [15:0] rsp_entry, mem_rdata;
  logic        mem_req, mem_ack;
  logic [16:0] mem_addr, last_addr;
  logic        cfg_wr, cfg_sel, cfg_epp, inv_all;
  logic [8:0]  cfg_base;
  int          total = 0, bad = 0, dly = 0;

  always #5 clk = ~clk;

  pmc_top dut_i (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_exec(lk_exec),
    .lk_ready(lk_ready), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_entry(rsp_entry),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_base(cfg_base), .cfg_epp(cfg_epp),
    .inv_all(inv_all));

  function automatic logic [15:0] md(input logic [16:0] a);
    return a[15:0] ^ 16'h5A3C;
  endfunction

  // memory model: acknowledges on the third edge after the request appears
  always @(posedge clk) begin
    #1;
    if (mem_ack) begin
      mem_ack = 1'b0;
      dly = 0;
    end else if (mem_req) begin
      dly++;
      if (dly == 3) begin
        mem_ack   = 1'b1;
        mem_rdata = md(mem_addr);
        last_addr = mem_addr;
      end
    end
  end

  task automatic chk(input logic ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic look(input logic [6:0] v, input logic e, input logic eh,
                      input logic [16:0] ea, input string rq);
    while (!lk_ready) @(negedge clk);
    lk_valid = 1'b1; lk_vpn = v; lk_exec = e;
    @(negedge clk);
    lk_valid = 1'b0;
    if (eh) begin
      chk(rsp_valid && rsp_hit && !mem_req, rq, {rsp_valid, rsp_hit, mem_req}, 3'b110);
    end else begin
      chk(!lk_ready && mem_req, "R7", {lk_ready, mem_req}, 2'b01);
      while (!mem_ack) @(negedge clk);
      chk(last_addr == ea, rq, last_addr, ea);
      @(negedge clk);
      chk(rsp_valid && !rsp_hit, rq, {rsp_valid, rsp_hit}, 2'b10);
    end
    chk(rsp_entry == md(ea), rq, rsp_entry, md(ea));
  endtask

  task automatic cfg(input logic sel, input logic [8:0] base, input logic epp);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_base = base; cfg_epp = epp;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic pulse_inv();
    inv_all = 1'b1;
    @(negedge clk);
    inv_all = 1'b0;
  endtask

  typedef struct packed {
    logic [6:0]  vpn;
    logic        ex;
    logic        hit;
    logic [16:0] addr;
  } vec_t;

  // User base 0x012, Exec base 0x034, shared-upper-Exec mode on
  localparam vec_t VTAB [6] = '{
    '{7'd5,   1'b0, 1'b0, 17'h01205},  // R4 user miss
    '{7'd5,   1'b0, 1'b1, 17'h01205},  // R3 hit
    '{7'd5,   1'b1, 1'b0, 17'h03405},  // R2 other mode misses
    '{7'd100, 1'b1, 1'b0, 17'h012E4},  // R5 upper Exec from User page
    '{7'd100, 1'b1, 1'b1, 17'h012E4},  // R3 hit
    '{7'd100, 1'b0, 1'b0, 17'h01264}   // R2 user page 100
  };

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; lk_valid = 1'b0; lk_vpn = '0; lk_exec = 1'b0;
    mem_ack = 1'b0; mem_rdata = '0; last_addr = '0;
    cfg_wr = 1'b0; cfg_sel = 1'b0; cfg_base = '0; cfg_epp = 1'b0; inv_all = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(lk_ready && !mem_req && !rsp_valid, "R1", {lk_ready, mem_req, rsp_valid}, 3'b100);

    cfg(1'b0, 9'h012, 1'b0);
    cfg(1'b1, 9'h034, 1'b1);
    for (int i = 0; i < 6; i++)
      look(VTAB[i].vpn, VTAB[i].ex, VTAB[i].hit, VTAB[i].addr, "R2_R3_R4_R5 table");

    // R8: new User base drops User and upper Exec entries only
    cfg(1'b0, 9'h056, 1'b0);
    look(7'd5,   1'b0, 1'b0, 17'h05605, "R8 user dropped");
    look(7'd5,   1'b1, 1'b1, 17'h03405, "R8 lower exec kept");
    look(7'd100, 1'b1, 1'b0, 17'h056E4, "R8 upper exec refetched");
    look(7'd100, 1'b0, 1'b0, 17'h05664, "R8 user 100 dropped");

    // R9: new Exec base with shared mode off drops Exec entries only
    cfg(1'b1, 9'h078, 1'b0);
    look(7'd5,   1'b1, 1'b0, 17'h07805, "R9 exec dropped");
    look(7'd100, 1'b1, 1'b0, 17'h07864, "R9 upper exec from exec map");
    look(7'd5,   1'b0, 1'b1, 17'h05605, "R9 user kept");

    // R10
    pulse_inv();
    look(7'd5, 1'b0, 1'b0, 17'h05605, "R10 inv_all");
    look(7'd5, 1'b1, 1'b0, 17'h07805, "R10 inv_all exec");

    // R6 / R12: eviction order with 8 entries
    pulse_inv();
    for (int v = 10; v < 18; v++) look(7'(v), 1'b0, 1'b0, {9'h056, 1'b0, 7'(v)}, "R6 fill");
    look(7'd10, 1'b0, 1'b1, 17'h0560A, "R6 touch");
    look(7'd20, 1'b0, 1'b0, 17'h05614, "R6 new miss");
    look(7'd10, 1'b0, 1'b1, 17'h0560A, "R6 touched kept");
    look(7'd11, 1'b0, 1'b0, 17'h0560B, "R6 LRU evicted");
    look(7'd13, 1'b0, 1'b1, 17'h0560D, "R12 capacity kept");
    look(7'd12, 1'b0, 1'b0, 17'h0560C, "R6 next LRU evicted");

    // R11: User base rewritten while a User refill is in flight
    while (!lk_ready) @(negedge clk);
    lk_valid = 1'b1; lk_vpn = 7'd7; lk_exec = 1'b0;
    @(negedge clk);
    lk_valid = 1'b0;
    cfg(1'b0, 9'h056, 1'b0);
    while (!mem_ack) @(negedge clk);
    @(negedge clk);
    chk(rsp_valid && !rsp_hit && rsp_entry == md(17'h05607), "R11 answered",
        {rsp_valid, rsp_hit, rsp_entry}, {2'b10, md(17'h05607)});
    look(7'd7, 1'b0, 1'b0, 17'h05607, "R11 not retained");

    // R7: lookup held while a refill is busy is only taken afterwards
    chk(lk_ready, "R7 idle again", lk_ready, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule